// File: doc/BRIEF.md
# General-Purpose I/O Port with Change Interrupt

This block is an 8-bit bidirectional I/O port for a small controller core. Software programs it through two registers on a simple register bus. The first is the port data register. The second holds one direction bit per pin. The block holds an output latch and drives the pad controls: an output value and an output enable for each pin. Reading the data register returns the pin levels after a two-flop synchronizer, not the contents of the latch.

A write to the data register is a read-modify-write. The bits selected by the write mask take the write data. Every other bit takes the level that its pin shows at that moment. A pin that is an input can therefore change the latch that sits behind it.

The upper four pins have a change detector. Each of these pins that is set as an input is compared against a snapshot. The snapshot is taken on every read strobe of the data register. A difference sets a sticky interrupt flag, which stays set until software clears it.

Top module: `gpio_ioc_port`

## Requirements
- R1: While reset is asserted and right after it, every direction bit is 1 (all pins are inputs, pad_oe = 0), the output latch is 0 (pad_out = 0), the snapshot is 0 and irq_flag is 0.
- R2: pad_out always equals the output latch. Bit i of pad_oe is the inverse of direction bit i, so a direction bit of 1 makes the pin an input and 0 makes it an output.
- R3: bus_rdata is combinational. With bus_sel = 0 it shows the synchronized pin levels, which follow pad_in by two clock edges. With bus_sel = 1 it shows the direction register.
- R4: A write with bus_sel = 0 stores (bus_wdata & bus_wmask) | (synchronized pins & ~bus_wmask) into the latch, and the latch then appears on pad_out. With no such write, pad_out holds its value.
- R5: A write with bus_sel = 1 changes only the direction bits selected by bus_wmask, which take bus_wdata. Without that write, the direction bits hold.
- R6: Changes on pins 3 to 0 never set irq_flag.
- R7: A pin among 7 to 4 whose direction bit is 0 (output) is excluded from the change comparison.
- R8: A detection occurs in a cycle when some input pin among 7 to 4 differs, after the synchronizer, from the snapshot. A read strobe with bus_sel = 0 loads the synchronized pins 7 to 4 into the snapshot at the next edge. The comparison in that same cycle still uses the old snapshot.
- R9: irq_flag is set at the edge after a detection and stays set until irq_clr. When irq_clr and a detection occur in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 data, 1 direction |
| bus_we | input | 1 | Write enable |
| bus_wmask | input | 8 | Bits affected by the write |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe (data read loads the snapshot) |
| bus_rdata | output | 8 | Read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output value to the pads |
| pad_oe | output | 8 | Per-pin output enable |
| irq_flag | output | 1 | Sticky change flag |
| irq_clr | input | 1 | Clears the change flag |

## Verification
The bench builds the block with its default parameters. That gives 8 pins, a watched field of pins 7 to 4 and two synchronizer stages. With 8 pins, random masks and levels cover every mix of inputs and outputs, watched and unwatched bits. With only two stages, reads and flag changes are easy to line up against pin changes. A same-cycle read and detection, a clear during a detection, and a write-back of pin levels that differ from the latch all turn up often.

// File: rtl/gpio_ioc_pkg.sv
package gpio_ioc_pkg;
  localparam int unsigned PORT_W   = 8;
  localparam int unsigned WATCH_LO = 4;

  // Masked bits take new_v, the rest keep base_v.
  function automatic logic [PORT_W-1:0] merge_bits(input logic [PORT_W-1:0] new_v,
                                                   input logic [PORT_W-1:0] base_v,
                                                   input logic [PORT_W-1:0] mask);
    return (new_v & mask) | (base_v & ~mask);
  endfunction

  // Any watched input that differs from the snapshot.
  function automatic logic watch_diff(input logic [PORT_W-WATCH_LO-1:0] pins,
                                      input logic [PORT_W-WATCH_LO-1:0] snap,
                                      input logic [PORT_W-WATCH_LO-1:0] is_in);
    return |((pins ^ snap) & is_in);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_ioc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              dir_wr,
  input  logic              data_rd,
  input  logic [PORT_W-1:0] wmask,
  input  logic [PORT_W-1:0] wdata,
  input  logic [PORT_W-1:0] pins,
  output logic [PORT_W-1:0] latch_q,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-WATCH_LO-1:0] snap_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '1;
      snap_q  <= '0;
    end else begin
      if (data_wr) latch_q <= merge_bits(wdata, pins, wmask);
      if (dir_wr)  dir_q   <= merge_bits(wdata, dir_q, wmask);
      if (data_rd) snap_q  <= pins[PORT_W-1:WATCH_LO];
    end
  end
endmodule

// File: rtl/gpio_chg.sv
module gpio_chg
  import gpio_ioc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] dir,
  input  logic [PORT_W-WATCH_LO-1:0] snap,
  input  logic              clr,
  output logic              hit,
  output logic              flag_q
);
  assign hit = watch_diff(pins[PORT_W-1:WATCH_LO], snap, dir[PORT_W-1:WATCH_LO]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (clr) flag_q <= 1'b0;
    else if (hit) flag_q <= 1'b1;
  end
endmodule

// File: rtl/gpio_ioc_port.sv
module gpio_ioc_port
  import gpio_ioc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [PORT_W-1:0] bus_wmask,
  input  logic [PORT_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pad_in,
  output logic [PORT_W-1:0] pad_out,
  output logic [PORT_W-1:0] pad_oe,
  output logic              irq_flag,
  input  logic              irq_clr
);
  logic [PORT_W-1:0] pins_s;
  logic [PORT_W-1:0] latch_q, dir_q;
  logic [PORT_W-WATCH_LO-1:0] snap_q;
  logic data_wr, dir_wr, data_rd, chg_hit;

  assign data_wr = bus_we && !bus_sel;
  assign dir_wr  = bus_we &&  bus_sel;
  assign data_rd = bus_re && !bus_sel;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pins_s));

  gpio_regs u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .dir_wr(dir_wr), .data_rd(data_rd),
    .wmask(bus_wmask), .wdata(bus_wdata), .pins(pins_s),
    .latch_q(latch_q), .dir_q(dir_q), .snap_q(snap_q));

  gpio_chg u_chg (
    .clk(clk), .rst_n(rst_n), .pins(pins_s), .dir(dir_q), .snap(snap_q),
    .clr(irq_clr), .hit(chg_hit), .flag_q(irq_flag));

  assign bus_rdata = bus_sel ? dir_q : pins_s;
  assign pad_out   = latch_q;
  assign pad_oe    = ~dir_q;
endmodule

// File: rtl/gpio_ioc_port_checker.sv
module gpio_ioc_port_checker
  import gpio_ioc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [PORT_W-1:0] bus_wmask,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] pad_out,
  input logic [PORT_W-1:0] pad_oe,
  input logic              irq_flag,
  input logic              irq_clr,
  input logic              hit
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0 && pad_out == '0 && !irq_flag));

  assert_dir_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel) |=>
      pad_oe == ~(($past(bus_wdata) & $past(bus_wmask)) | (~$past(pad_oe) & ~$past(bus_wmask))));

  assert_dir_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_sel) |=> $stable(pad_oe));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && !bus_sel) |=> $stable(pad_out));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_flag);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_set_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !irq_clr) |=> irq_flag);

  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !hit) |=> !irq_flag);
endmodule

bind gpio_ioc_port gpio_ioc_port_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_wmask(bus_wmask), .bus_wdata(bus_wdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq_flag(irq_flag), .irq_clr(irq_clr), .hit(chg_hit));

// File: tb/gpio_ioc_port_bench.sv
module gpio_ioc_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0, bus_re = 1'b0, irq_clr = 1'b0;
  logic [7:0] bus_wmask = '0, bus_wdata = '0, pad_in = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe;
  logic irq_flag;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ioc_port u_gpio_ioc_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wmask(bus_wmask), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq_flag(irq_flag), .irq_clr(irq_clr));

  // Reference model, written from the requirements.
  logic [7:0] m_p1, m_p2, m_latch, m_dir;
  logic [3:0] m_snap;
  logic m_flag;

  function automatic logic [7:0] exp_merge(logic [7:0] w, logic [7:0] keep, logic [7:0] m);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = m[i] ? w[i] : keep[i];
    return r;
  endfunction

  function automatic logic exp_detect(logic [7:0] p, logic [3:0] s, logic [7:0] d);
    for (int i = 4; i < 8; i++)
      if (d[i] && (p[i] != s[i-4])) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 <= '0; m_p2 <= '0; m_latch <= '0; m_dir <= '1; m_snap <= '0; m_flag <= 1'b0;
    end else begin
      m_p1 <= pad_in;
      m_p2 <= m_p1;
      if (bus_we && !bus_sel) m_latch <= exp_merge(bus_wdata, m_p2, bus_wmask);
      if (bus_we &&  bus_sel) m_dir   <= exp_merge(bus_wdata, m_dir, bus_wmask);
      if (bus_re && !bus_sel) m_snap  <= m_p2[7:4];
      if (irq_clr) m_flag <= 1'b0;
      else if (exp_detect(m_p2, m_snap, m_dir)) m_flag <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_model();
    check(pad_out == m_latch, "R4 latch on pad_out", pad_out, m_latch);
    check(pad_oe == ~m_dir, "R2 R5 output enable", pad_oe, ~m_dir);
    check(bus_rdata == (bus_sel ? m_dir : m_p2), "R3 read data", bus_rdata,
          bus_sel ? m_dir : m_p2);
    check(irq_flag == m_flag, "R8 R9 change flag", {7'd0, irq_flag}, {7'd0, m_flag});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    step(2);
    // R1 reset values
    check(pad_oe == 8'h00, "R1 oe in reset", pad_oe, 8'h00);
    check(pad_out == 8'h00, "R1 latch in reset", pad_out, 8'h00);
    check(irq_flag == 1'b0, "R1 flag in reset", {7'd0, irq_flag}, 8'h00);
    rst_n = 1'b1;
    bus_sel = 1'b1; step(1);
    check(bus_rdata == 8'hFF, "R1 R3 direction after reset", bus_rdata, 8'hFF);
    // Snapshot of quiet pins, then change a low pin only.
    bus_sel = 1'b0; bus_re = 1'b1; step(1); bus_re = 1'b0;
    pad_in = 8'h01; step(4);
    check(irq_flag == 1'b0, "R6 low pin ignored", {7'd0, irq_flag}, 8'h00);
    check(bus_rdata == 8'h01, "R3 pin level read", bus_rdata, 8'h01);
    // Upper input pin change.
    pad_in = 8'h21; step(4);
    check(irq_flag == 1'b1, "R8 upper change sets flag", {7'd0, irq_flag}, 8'h01);
    // Clear while the mismatch persists: clear wins, then sets again.
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
    check(irq_flag == 1'b0, "R9 clear wins", {7'd0, irq_flag}, 8'h00);
    step(1);
    check(irq_flag == 1'b1, "R9 set again", {7'd0, irq_flag}, 8'h01);
    // Read refreshes snapshot.
    bus_re = 1'b1; irq_clr = 1'b1; step(1); bus_re = 1'b0; irq_clr = 1'b0; step(2);
    check(irq_flag == 1'b0, "R8 snapshot refreshed", {7'd0, irq_flag}, 8'h00);
    // Upper pins become outputs.
    bus_sel = 1'b1; bus_we = 1'b1; bus_wmask = 8'hFF; bus_wdata = 8'h0F; step(1);
    bus_we = 1'b0;
    check(pad_oe == 8'hF0, "R2 R5 upper outputs", pad_oe, 8'hF0);
    pad_in = 8'hE1; step(4);
    check(irq_flag == 1'b0, "R7 output pins excluded", {7'd0, irq_flag}, 8'h00);
    // Read-modify-write of the latch.
    bus_sel = 1'b0; bus_we = 1'b1; bus_wmask = 8'hF0; bus_wdata = 8'hA5; step(1);
    bus_we = 1'b0;
    check(pad_out == 8'hA1, "R4 masked write merges pins", pad_out, 8'hA1);

    // Random phase against the model.
    for (int c = 0; c < RAND_CYCLES; c++) begin
      if (c == RAND_CYCLES / 2) rst_n = 1'b0;
      else rst_n = 1'b1;
      if (($urandom % 6) == 0) pad_in = pad_in ^ (8'(1) << ($urandom % 8));
      bus_sel   = 1'($urandom % 2);
      bus_we    = (($urandom % 4) == 0);
      bus_re    = (($urandom % 5) == 0);
      irq_clr   = (($urandom % 8) == 0);
      bus_wmask = 8'($urandom);
      bus_wdata = 8'($urandom);
      #1;
      check_model();
      step(1);
    end
    check_model();
    finish_run();
  end
endmodule